// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block produces the address sequence of a quadratic permutation polynomial interleaver. For a modulus M and coefficients f1 and f2, it emits pi(c) = (f1*c + f2*c^2) mod M for c = 0, 1, ..., M-1 as an output stream. It emits one address per clock cycle while the consumer accepts. The datapath keeps a running address and a running first difference. It uses only additions, each followed by a conditional subtraction of M. It has no multiplier and no divider. A turbo decoder uses one instance with the full block size K and the table coefficients to get the linear interleaved address. It uses a second instance to get the in-bank address. That second instance is loaded with modulus S = K/p, where p is a power of two up to 64 that divides K, and with the coefficients f1 mod S and f2 mod S. The value it yields at step c is the address that every one of the p parallel sub-blocks reads at that step.

A one-cycle pulse on `i_start` loads the coefficients and the modulus and starts a new sequence. This happens whether or not a sequence is already running. The output is a valid/ready stream. A beat transfers on a clock edge where `o_valid` and `i_ready` are both high. While `o_valid` is high and `i_ready` is low, the generator holds `o_addr`, `o_index` and `o_last` unchanged and does not advance. `o_valid` never drops before the final beat has transferred. After the final beat `o_valid` stays low until the next start pulse. The caller must supply 1 <= M <= 2^AW-1, f1 < M and f2 < M.

Top module: `quad_perm_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start pulse, `o_valid` is low.
- R2: In the cycle after an `i_start` pulse, `o_valid` is high, `o_addr` is 0 and `o_index` is 0.
- R3: The beat with `o_index` = c carries `o_addr` = (f1*c + f2*c^2) mod M, using the values on `i_coef_lin`, `i_coef_quad` and `i_modulus` at the start pulse. Every address is below M.
- R4: Once started, `o_valid` stays high until the beat with index M-1 transfers. With `i_ready` held high, one address transfers every cycle and there are no gaps.
- R5: While `o_valid` is high and `i_ready` is low, `o_addr`, `o_index` and `o_last` hold their values and the sequence does not advance.
- R6: `o_last` is high exactly on the beat with index M-1. After that beat transfers, `o_valid` is low in the next cycle and stays low until a new start pulse.
- R7: A start pulse in the middle of a sequence abandons it. The next cycle presents index 0 with address 0 under the newly loaded parameters.
- R8: When loaded with modulus S = K/p and coefficients f1 mod S and f2 mod S, the beat with index c carries pi_K(c + j*S) mod S, and this value is the same for every j from 0 to p-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_start | input | 1 | One-cycle pulse: load the parameters and restart the sequence |
| i_coef_lin | input | AW | Linear coefficient f1, must be below the modulus |
| i_coef_quad | input | AW | Quadratic coefficient f2, must be below the modulus |
| i_modulus | input | AW | Modulus M (block size K or sub-block size S), at least 1 |
| o_valid | output | 1 | Output beat available |
| i_ready | input | 1 | Consumer accepts the beat |
| o_addr | output | AW | Permuted address for the current index |
| o_index | output | AW | Step index c of the current beat |
| o_last | output | 1 | Current beat is index M-1 |

## Verification
Full-length sequences are run for several valid (K, f1, f2) triples, from the smallest block to the largest. Short blocks expose errors in the initial difference and the first wrap. The largest block exposes errors at the widest carries and wraps. Each run is repeated with `i_ready` held high and with random back-pressure at different densities. The held-high runs show that the stream has no gaps. The random runs show that a stalled beat neither advances nor changes. A restart in the middle of a sequence shows that a fresh start discards the old state. Reduced-modulus runs are compared against the full-length formula at every sub-block offset. They show that the in-bank address is shared by all sub-blocks.

// File: rtl/qpa_pkg.sv
package qpa_pkg;
  localparam int unsigned QPA_AW_DEF = 13;

  typedef enum logic {
    QPA_IDLE = 1'b0,
    QPA_RUN  = 1'b1
  } qpa_state_e;
endpackage

// File: rtl/qpa_mod_add.sv
module qpa_mod_add #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] i_a,
  input  logic [W-1:0] i_b,
  input  logic [W-1:0] i_m,
  output logic [W-1:0] o_y
);
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         wrap;

  // Operands are below the modulus, so one subtraction is enough.
  assign sum  = {1'b0, i_a} + {1'b0, i_b};
  assign wrap = (sum >= {1'b0, i_m});
  assign diff = sum[W-1:0] - i_m;
  assign o_y  = wrap ? diff : sum[W-1:0];
endmodule

// File: rtl/qpa_recur_core.sv
module qpa_recur_core #(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_load,
  input  logic          i_adv,
  input  logic [AW-1:0] i_f1,
  input  logic [AW-1:0] i_f2,
  input  logic [AW-1:0] i_mod,
  output logic [AW-1:0] o_pi
);
  logic [AW-1:0] mod_q, pi_q, diff_q, step_q;
  logic [AW-1:0] diff_init, step_init, pi_next, diff_next;

  // Initial first difference: pi(1) - pi(0) = f1 + f2
  qpa_mod_add #(.W(AW)) u_diff_init (
    .i_a(i_f1), .i_b(i_f2), .i_m(i_mod), .o_y(diff_init)
  );
  // Constant second difference: 2*f2
  qpa_mod_add #(.W(AW)) u_step_init (
    .i_a(i_f2), .i_b(i_f2), .i_m(i_mod), .o_y(step_init)
  );
  qpa_mod_add #(.W(AW)) u_pi_next (
    .i_a(pi_q), .i_b(diff_q), .i_m(mod_q), .o_y(pi_next)
  );
  qpa_mod_add #(.W(AW)) u_diff_next (
    .i_a(diff_q), .i_b(step_q), .i_m(mod_q), .o_y(diff_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q  <= '0;
      pi_q   <= '0;
      diff_q <= '0;
      step_q <= '0;
    end else if (i_load) begin
      mod_q  <= i_mod;
      pi_q   <= '0;
      diff_q <= diff_init;
      step_q <= step_init;
    end else if (i_adv) begin
      pi_q   <= pi_next;
      diff_q <= diff_next;
    end
  end

  assign o_pi = pi_q;

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |-> (pi_q < mod_q)); // R3
  AST_DIFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q != '0) |-> (diff_q < mod_q)); // R3
  AST_ZERO_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    i_load |=> (o_pi == '0)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!i_adv && !i_load) |=> $stable(o_pi)); // R5
endmodule

// File: rtl/qpa_seq_ctrl.sv
module qpa_seq_ctrl
  import qpa_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  logic          i_ready,
  input  logic [AW-1:0] i_mod,
  output logic          o_valid,
  output logic [AW-1:0] o_index,
  output logic          o_last,
  output logic          o_load,
  output logic          o_adv
);
  qpa_state_e    state_q;
  logic [AW-1:0] idx_q, lim_q;
  logic          xfer;

  assign xfer    = (state_q == QPA_RUN) && i_ready;
  assign o_load  = i_start;
  assign o_adv   = xfer && !i_start;
  assign o_valid = (state_q == QPA_RUN);
  assign o_index = idx_q;
  assign o_last  = o_valid && (idx_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= QPA_IDLE;
      idx_q   <= '0;
      lim_q   <= '0;
    end else if (i_start) begin
      state_q <= QPA_RUN;
      idx_q   <= '0;
      lim_q   <= i_mod - 1'b1;
    end else if (xfer) begin
      if (idx_q == lim_q) begin
        state_q <= QPA_IDLE;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    i_start |=> (o_valid && o_index == '0)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready && !i_start) |=> (o_valid && $stable(o_index) && $stable(o_last))); // R5
  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && i_ready && o_last && !i_start) |=> !o_valid); // R6
  AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_last) |=> o_valid); // R4
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!o_valid && !i_start) |=> !o_valid); // R6
endmodule

// File: rtl/quad_perm_addr_gen.sv
module quad_perm_addr_gen
  import qpa_pkg::*;
#(
  parameter int unsigned AW = QPA_AW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          i_start,
  input  logic [AW-1:0] i_coef_lin,
  input  logic [AW-1:0] i_coef_quad,
  input  logic [AW-1:0] i_modulus,
  output logic          o_valid,
  input  logic          i_ready,
  output logic [AW-1:0] o_addr,
  output logic [AW-1:0] o_index,
  output logic          o_last
);
  logic load, adv;

  qpa_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_start (i_start),
    .i_ready (i_ready),
    .i_mod   (i_modulus),
    .o_valid (o_valid),
    .o_index (o_index),
    .o_last  (o_last),
    .o_load  (load),
    .o_adv   (adv)
  );

  qpa_recur_core #(.AW(AW)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .i_load (load),
    .i_adv  (adv),
    .i_f1   (i_coef_lin),
    .i_f2   (i_coef_quad),
    .i_mod  (i_modulus),
    .o_pi   (o_addr)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !o_valid); // R1
  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !i_ready && !i_start) |=> $stable(o_addr)); // R5
endmodule

// File: tb/quad_perm_addr_gen_tb.sv
module quad_perm_addr_gen_tb;
  localparam int AW = 13;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] f1 = '0, f2 = '0, modv = '0;
  logic          ready = 1'b0;
  logic          valid, last;
  logic [AW-1:0] addr, index;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  quad_perm_addr_gen #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_start(start),
    .i_coef_lin(f1), .i_coef_quad(f2), .i_modulus(modv),
    .o_valid(valid), .i_ready(ready), .o_addr(addr),
    .o_index(index), .o_last(last)
  );

  function automatic int unsigned ref_pi(int unsigned a, int unsigned b,
                                         int unsigned k, int unsigned c);
    longint unsigned t;
    t = (longint'(a) * c + longint'(b) * c * c) % k;
    return int'(t);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // m/a/b: loaded modulus and coefficients. refk/ra/rb/nsub: reference
  // formula and number of sub-block offsets that must all agree.
  task automatic run_stream(input int m, input int a, input int b, input int rdy_pct,
                            input int refk, input int ra, input int rb,
                            input int nsub, input int abort_after);
    int c = 0;
    bit stalled = 0;
    int s_addr = 0, s_idx = 0;
    @(negedge clk);
    start = 1'b1; modv = AW'(m); f1 = AW'(a); f2 = AW'(b); ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(valid && addr == 0 && index == 0, "R2", int'(addr), 0);
    while (c < m && cyc < LIMIT) begin
      if (stalled)  // R5
        check(valid && addr == s_addr && index == s_idx, "R5", int'(addr), s_addr);
      ready = ($urandom_range(99) < rdy_pct);
      if (!valid) begin
        check(1'b0, "R4", 0, 1);  // R4: no drop before final beat
      end else if (ready) begin
        int exp;
        bit same = 1'b1;
        exp = int'(ref_pi(ra, rb, refk, c) % m);
        for (int j = 1; j < nsub; j++)
          if (int'(ref_pi(ra, rb, refk, c + j * m) % m) != exp) same = 1'b0;
        check(int'(addr) == exp && same, (nsub > 1) ? "R8" : "R3", int'(addr), exp);
        check(int'(index) == c, "R3", int'(index), c);
        check(last == (c == m - 1), "R6", int'(last), int'(c == m - 1));
        stalled = 1'b0;
        c++;
        if (abort_after != 0 && c == abort_after) return;
      end else begin
        stalled = 1'b1; s_addr = int'(addr); s_idx = int'(index);
      end
      @(negedge clk);
    end
    check(!valid, "R6", int'(valid), 0);
    for (int i = 0; i < 4; i++) begin
      ready = $urandom_range(1);
      @(negedge clk);
      check(!valid, "R6", int'(valid), 0);
    end
  endtask

  task automatic run_full(input int k, input int a, input int b, input int rdy);
    run_stream(k, a, b, rdy, k, a, b, 1, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!valid, "R1", int'(valid), 0);  // R1 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!valid, "R1", int'(valid), 0);  // R1 after release, no start

    // Directed: ready held high (R4 gap-free), several valid triples
    run_full(40, 3, 10, 100);
    run_full(512, 31, 64, 100);
    run_full(6144, 263, 480, 100);
    // Back-pressure at different densities (R5)
    run_full(40, 3, 10, 30);
    run_full(1024, 31, 64, 50);
    run_full(6144, 263, 480, 75);
    // R7: restart in mid-sequence with new parameters
    run_stream(2048, 31, 64, 60, 2048, 31, 64, 1, 17);
    run_full(4096, 31, 64, 90);
    // R8: reduced modulus gives the shared in-bank address
    run_stream(192, 71, 96, 100, 6144, 263, 480, 32, 0);
    run_stream(5, 3, 0, 40, 40, 3, 10, 8, 0);
    run_stream(64, 31, 0, 70, 2048, 31, 64, 32, 0);
    // Random picks of triples and ready density
    for (int r = 0; r < 4; r++) begin
      int sel = int'($urandom_range(3));
      int pct = 40 + int'($urandom_range(60));
      case (sel)
        0: run_full(40, 3, 10, pct);
        1: run_full(512, 31, 64, pct);
        2: run_full(1024, 31, 64, pct);
        default: run_full(2048, 31, 64, pct);
      endcase
    end

    if (cyc >= LIMIT) check(1'b0, "watchdog", cyc, LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= LIMIT + 1000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule